// File: doc/BRIEF.md
# Lookahead Issue Gate for an Interleaved Multithread Pipeline

This block sits in front of a deep, non-bypassed pipeline that is shared by many hardware threads. Each cycle it picks at most one thread whose next instruction may enter the pipeline. A thread is allowed to issue when it is active and has an instruction waiting. It must also have left its previous issue far enough behind, and it must not have used up the independence allowance of its most recent long-latency operation.

Every instruction carries a 3-bit count, set by the compiler, of how many of the thread's later instructions do not depend on it. When a thread issues a memory operation, the block records that the operation is outstanding and loads the count. Each later issue by that thread uses up one unit of the allowance. When the allowance reaches zero and the operation is still outstanding, the thread waits. A completion input tagged with a thread number ends the wait. Threads are switched on and off through tagged create and terminate inputs. Grants rotate among the eligible threads.

Top module: `mt_issue_gate`

## Requirements
- R1: After reset every thread is inactive: `elig` is all zero and `grant_vld` is 0, whatever the other inputs are.
- R2: A create pulse makes the tagged thread active from the next cycle, and a terminate pulse makes it inactive. If both tag the same thread in the same cycle, terminate wins. An inactive thread is never eligible and never granted.
- R3: After a thread is granted, it is not eligible for the next 20 cycles. It may be granted again in the 21st cycle after its grant, so the spacing is 21 cycles.
- R4: Granting a thread whose head is a memory operation (`head_mem`=1) with lookahead L marks the operation outstanding and allows L further grants of that thread. After those grants the thread is not eligible while the operation is outstanding.
- R5: A memory operation with lookahead 0 blocks its thread from the next issue slot onward, until the thread's completion arrives.
- R6: A completion tagged with a thread number clears that thread's outstanding flag. The thread becomes eligible again in the next cycle, subject to R2, R3 and R10. A completion for another thread does not change it.
- R7: A memory operation issued while an earlier one is still outstanding replaces the remaining allowance with its own lookahead.
- R8: `grant_vld` is 1 exactly when some bit of `elig` is 1. A granted thread is always eligible. At most one thread is granted per cycle.
- R9: The search starts at the thread after the last granted one and wraps around. After reset, thread 0 has the highest priority.
- R10: A thread whose `head_valid` bit is 0 is not eligible.
- R11: If the same thread issues a new memory operation and receives a completion in the same cycle, the new operation stays outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| create_vld | input | 1 | Activate the thread named by create_tid |
| create_tid | input | 4 | Thread to activate |
| term_vld | input | 1 | Deactivate the thread named by term_tid |
| term_tid | input | 4 | Thread to deactivate |
| cmpl_vld | input | 1 | Long-latency operation of cmpl_tid completed |
| cmpl_tid | input | 4 | Thread whose operation completed |
| head_valid | input | 16 | Per thread: next instruction is available |
| head_mem | input | 16 | Per thread: next instruction is a memory operation |
| head_la | input | 48 | Per thread, 3 bits each (thread t at bits 3t+2..3t): lookahead of the next instruction |
| grant_vld | output | 1 | A thread issues this cycle |
| grant_tid | output | 4 | Thread that issues |
| elig | output | 16 | Per-thread eligibility this cycle |

## Verification
If a thread's spacing counter is corrupted, its `elig` bit rises too early or too late. This is visible at the port in the first cycle that differs from the 21-cycle rhythm. If the allowance or the outstanding flag is wrong, the error stays hidden until the thread's next issue slot. There it shows up as one grant too many or too few, or as a thread that stays blocked after its completion. A stale rotation pointer shows up at the first cycle in which two threads are eligible and the wrong one is granted.

// File: rtl/mtig_pkg.sv
package mtig_pkg;
  localparam int unsigned NUM_THREADS = 16;
  localparam int unsigned PIPE_DEPTH  = 21;
  localparam int unsigned LA_BITS     = 3;
  localparam int unsigned TID_W       = $clog2(NUM_THREADS);
  localparam int unsigned GAP_W       = $clog2(PIPE_DEPTH);

  typedef logic [TID_W-1:0]   tid_t;
  typedef logic [GAP_W-1:0]   gap_t;
  typedef logic [LA_BITS-1:0] la_t;

  typedef struct packed {
    logic hit;
    tid_t tid;
  } pick_t;

  // cycles a thread must sit out after an issue
  function automatic gap_t gap_reload();
    return gap_t'(PIPE_DEPTH - 1);
  endfunction

  // outstanding operation with no independent successors left
  function automatic logic lookahead_spent(input logic pend, input la_t left);
    return pend && (left == '0);
  endfunction

  function automatic la_t la_consume(input la_t left);
    return left - 1'b1;
  endfunction
endpackage

// File: rtl/mtig_tid_dec.sv
module mtig_tid_dec
  import mtig_pkg::*;
(
  input  logic                   vld_i,
  input  tid_t                   tid_i,
  output logic [NUM_THREADS-1:0] sel_o
);
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_sel
    assign sel_o[g] = vld_i && (tid_i == tid_t'(g));
  end
endmodule

// File: rtl/mtig_thread_ctx.sv
module mtig_thread_ctx
  import mtig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic create_i,
  input  logic term_i,
  input  logic issue_i,
  input  logic head_valid_i,
  input  logic head_mem_i,
  input  la_t  head_la_i,
  input  logic cmpl_i,
  output logic elig_o
);
  logic active_q;
  gap_t gap_q;
  la_t  la_q;
  logic pend_q;

  // named internal events
  logic spacing_w;
  logic blocked_w;
  logic mem_issue_w;
  logic fresh_w;

  assign spacing_w   = (gap_q != '0);
  assign blocked_w   = lookahead_spent(pend_q, la_q);
  assign mem_issue_w = issue_i && head_mem_i;
  assign fresh_w     = create_i && !term_i;
  assign elig_o      = active_q && head_valid_i && !spacing_w && !blocked_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      gap_q    <= '0;
      la_q     <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (term_i)        active_q <= 1'b0;
      else if (create_i) active_q <= 1'b1;

      if (fresh_w) begin
        gap_q  <= '0;
        la_q   <= '0;
        pend_q <= 1'b0;
      end else begin
        if (issue_i)        gap_q <= gap_reload();
        else if (spacing_w) gap_q <= gap_q - 1'b1;

        if (mem_issue_w) begin
          pend_q <= 1'b1;
          la_q   <= head_la_i;
        end else begin
          if (cmpl_i) pend_q <= 1'b0;
          if (issue_i && pend_q) la_q <= la_consume(la_q);
        end
      end
    end
  end

  assert_issue_elig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> elig_o);
  assert_inactive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !issue_i);
  assert_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> !elig_o);
  assert_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && la_q == '0 && !cmpl_i && !create_i) |=> !elig_o);
  assert_cmpl_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_i && !create_i && !mem_issue_w) |=> !pend_q);
  assert_race_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_issue_w && !fresh_w) |=> pend_q);
endmodule

// File: rtl/mtig_rr_arb.sv
module mtig_rr_arb
  import mtig_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] req_i,
  output logic                   gnt_vld_o,
  output tid_t                   gnt_tid_o,
  output logic [NUM_THREADS-1:0] gnt_oh_o
);
  tid_t  last_q;
  pick_t pick_w;

  // scan from farthest to nearest so the nearest requester after last wins
  function automatic pick_t rr_pick(input logic [NUM_THREADS-1:0] req, input tid_t last);
    pick_t r;
    int unsigned idx;
    r.hit = 1'b0;
    r.tid = '0;
    for (int k = NUM_THREADS; k >= 1; k--) begin
      idx = (int'(last) + k) % NUM_THREADS;
      if (req[idx]) begin
        r.hit = 1'b1;
        r.tid = tid_t'(idx);
      end
    end
    return r;
  endfunction

  assign pick_w    = rr_pick(req_i, last_q);
  assign gnt_vld_o = pick_w.hit;
  assign gnt_tid_o = pick_w.tid;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_oh
    assign gnt_oh_o[g] = pick_w.hit && (pick_w.tid == tid_t'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         last_q <= tid_t'(NUM_THREADS - 1);
    else if (pick_w.hit) last_q <= pick_w.tid;
  end

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oh_o));
  assert_grant_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> req_i[gnt_tid_o]);
  assert_work_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> gnt_vld_o);
endmodule

// File: rtl/mt_issue_gate.sv
module mt_issue_gate
  import mtig_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           create_vld,
  input  logic [TID_W-1:0]               create_tid,
  input  logic                           term_vld,
  input  logic [TID_W-1:0]               term_tid,
  input  logic                           cmpl_vld,
  input  logic [TID_W-1:0]               cmpl_tid,
  input  logic [NUM_THREADS-1:0]         head_valid,
  input  logic [NUM_THREADS-1:0]         head_mem,
  input  logic [NUM_THREADS*LA_BITS-1:0] head_la,
  output logic                           grant_vld,
  output logic [TID_W-1:0]               grant_tid,
  output logic [NUM_THREADS-1:0]         elig
);
  logic [NUM_THREADS-1:0] create_sel;
  logic [NUM_THREADS-1:0] term_sel;
  logic [NUM_THREADS-1:0] cmpl_sel;
  logic [NUM_THREADS-1:0] issue_oh;

  mtig_tid_dec u_create_dec (.vld_i(create_vld), .tid_i(create_tid), .sel_o(create_sel));
  mtig_tid_dec u_term_dec   (.vld_i(term_vld),   .tid_i(term_tid),   .sel_o(term_sel));
  mtig_tid_dec u_cmpl_dec   (.vld_i(cmpl_vld),   .tid_i(cmpl_tid),   .sel_o(cmpl_sel));

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_ctx
    mtig_thread_ctx u_ctx (
      .clk         (clk),
      .rst_n       (rst_n),
      .create_i    (create_sel[g]),
      .term_i      (term_sel[g]),
      .issue_i     (issue_oh[g]),
      .head_valid_i(head_valid[g]),
      .head_mem_i  (head_mem[g]),
      .head_la_i   (head_la[g*LA_BITS +: LA_BITS]),
      .cmpl_i      (cmpl_sel[g]),
      .elig_o      (elig[g])
    );
  end

  mtig_rr_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (elig),
    .gnt_vld_o(grant_vld),
    .gnt_tid_o(grant_tid),
    .gnt_oh_o (issue_oh)
  );

  assert_respace_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |=> !(grant_vld && grant_tid == $past(grant_tid)));
endmodule

// File: tb/mt_issue_gate_tb_top.sv
`timescale 1ns/1ps
module mt_issue_gate_tb_top;
  localparam int NT  = 16;
  localparam int LAW = 3;
  localparam int GAP = 20; // idle cycles between issues of one thread

  logic clk = 1'b0;
  logic rst_n;
  logic create_vld, term_vld, cmpl_vld;
  logic [3:0] create_tid, term_tid, cmpl_tid;
  logic [NT-1:0] head_valid, head_mem;
  logic [NT*LAW-1:0] head_la;
  logic grant_vld;
  logic [3:0] grant_tid;
  logic [NT-1:0] elig;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mt_issue_gate dut_i (
    .clk(clk), .rst_n(rst_n),
    .create_vld(create_vld), .create_tid(create_tid),
    .term_vld(term_vld), .term_tid(term_tid),
    .cmpl_vld(cmpl_vld), .cmpl_tid(cmpl_tid),
    .head_valid(head_valid), .head_mem(head_mem), .head_la(head_la),
    .grant_vld(grant_vld), .grant_tid(grant_tid), .elig(elig)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();  @(posedge clk); #1; endtask
  task automatic settle(); #1; endtask
  task automatic idle(input int n); repeat (n) cyc(); endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    create_vld = 0; term_vld = 0; cmpl_vld = 0;
    create_tid = 0; term_tid = 0; cmpl_tid = 0;
    head_valid = '0; head_mem = '0; head_la = '0;
    idle(2);
    rst_n = 1'b1;
    cyc();
    settle();
  endtask

  task automatic create(input int t);
    create_vld = 1; create_tid = 4'(t);
    cyc();
    create_vld = 0;
    settle();
  endtask

  task automatic set_head(input int t, input bit mem, input int la);
    head_mem[t] = mem;
    head_la[t*LAW +: LAW] = 3'(la);
  endtask

  task automatic expect_grant(input string tag, input int t);
    chk({tag, " grant_vld"}, int'(grant_vld), 1);
    chk({tag, " grant_tid"}, int'(grant_tid), t);
  endtask

  task automatic t_reset_r1();
    do_reset();
    head_valid = '1;
    settle();
    chk("R1 elig after reset", int'(elig), 0);
    chk("R1 grant after reset", int'(grant_vld), 0);
  endtask

  task automatic t_spacing_r3();
    do_reset();
    head_valid = '1;
    create(3);
    expect_grant("R2 created thread", 3);
    cyc(); settle();
    for (int k = 1; k <= GAP; k++) begin
      chk("R3 spacing elig", int'(elig[3]), 0);
      chk("R3 spacing grant", int'(grant_vld), 0);
      cyc(); settle();
    end
    expect_grant("R3 regrant at 21", 3);
  endtask

  task automatic t_active_r2_r10();
    do_reset();
    head_valid = '1;
    settle();
    chk("R2 no active thread", int'(grant_vld), 0);
    head_valid = '0;
    create(7);
    chk("R10 head invalid elig", int'(elig[7]), 0);
    chk("R10 head invalid grant", int'(grant_vld), 0);
    head_valid[7] = 1; settle();
    expect_grant("R10 head valid", 7);
    head_valid[7] = 0;
    term_vld = 1; term_tid = 4'd7;
    cyc();
    term_vld = 0;
    head_valid = '1; settle();
    chk("R2 terminated elig", int'(elig[7]), 0);
    chk("R2 terminated grant", int'(grant_vld), 0);
    create_vld = 1; create_tid = 4'd9; term_vld = 1; term_tid = 4'd9;
    cyc();
    create_vld = 0; term_vld = 0; settle();
    chk("R2 terminate wins", int'(elig[9]), 0);
    chk("R2 terminate wins grant", int'(grant_vld), 0);
  endtask

  task automatic t_lookahead_r4();
    do_reset();
    create(2);
    head_valid[2] = 1; set_head(2, 1, 2); settle();
    expect_grant("R4 mem issue", 2);
    cyc(); set_head(2, 0, 0);
    for (int k = 0; k < 2; k++) begin
      idle(GAP); settle();
      expect_grant("R4 independent issue", 2);
      cyc();
    end
    idle(GAP); settle();
    chk("R4 allowance spent elig", int'(elig[2]), 0);
    chk("R4 allowance spent grant", int'(grant_vld), 0);
    idle(5); settle();
    chk("R4 still blocked", int'(elig[2]), 0);
    cmpl_vld = 1; cmpl_tid = 4'd2;
    cyc();
    cmpl_vld = 0; settle();
    expect_grant("R6 completion releases", 2);
  endtask

  task automatic t_zero_r5();
    do_reset();
    create(5);
    head_valid[5] = 1; set_head(5, 1, 0); settle();
    expect_grant("R5 mem la0", 5);
    cyc(); set_head(5, 0, 0);
    idle(GAP); settle();
    chk("R5 blocked elig", int'(elig[5]), 0);
    chk("R5 blocked grant", int'(grant_vld), 0);
    cmpl_vld = 1; cmpl_tid = 4'd6;
    cyc();
    cmpl_vld = 0; settle();
    chk("R6 other tag no effect", int'(elig[5]), 0);
    cmpl_vld = 1; cmpl_tid = 4'd5;
    cyc();
    cmpl_vld = 0; settle();
    expect_grant("R6 own tag releases", 5);
  endtask

  task automatic t_reload_r7();
    do_reset();
    create(11);
    head_valid[11] = 1; set_head(11, 1, 1); settle();
    expect_grant("R7 first mem", 11);
    cyc(); idle(GAP);
    set_head(11, 1, 3); settle();
    expect_grant("R7 second mem", 11);
    cyc(); set_head(11, 0, 0);
    for (int k = 0; k < 3; k++) begin
      idle(GAP); settle();
      expect_grant("R7 reloaded allowance", 11);
      cyc();
    end
    idle(GAP); settle();
    chk("R7 reload spent", int'(elig[11]), 0);
  endtask

  task automatic t_race_r11();
    do_reset();
    create(13);
    head_valid[13] = 1; set_head(13, 1, 1); settle();
    expect_grant("R11 first mem", 13);
    cyc(); idle(GAP);
    set_head(13, 1, 0);
    cmpl_vld = 1; cmpl_tid = 4'd13; settle();
    expect_grant("R11 mem with completion", 13);
    cyc();
    cmpl_vld = 0; set_head(13, 0, 0);
    idle(GAP); settle();
    chk("R11 new op outstanding", int'(elig[13]), 0);
  endtask

  task automatic t_rotate_r8_r9();
    do_reset();
    create(1); create(4); create(9);
    head_valid = '1; settle();
    chk("R8 elig vector", int'(elig), 32'h0212);
    expect_grant("R9 reset priority", 1);
    cyc(); settle();
    expect_grant("R9 next after 1", 4);
    cyc(); settle();
    expect_grant("R9 next after 4", 9);
    cyc(); settle();
    chk("R8 none eligible", int'(grant_vld), 0);
    head_valid = '0;
    create(0); create(12);
    head_valid[0] = 1; head_valid[12] = 1; settle();
    expect_grant("R9 search after last", 12);
    cyc(); settle();
    expect_grant("R9 wrap", 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    t_reset_r1();
    t_spacing_r3();
    t_active_r2_r10();
    t_lookahead_r4();
    t_zero_r5();
    t_reload_r7();
    t_race_r11();
    t_rotate_r8_r9();
    summary();
  end
endmodule